// File: doc/BRIEF.md
# Operate Execution Unit with Sign Flags

This block carries out the register-to-register arithmetic and logic instructions of a 16-bit processor: addition, bitwise AND and bitwise complement. Each cycle it decodes the presented instruction word. It takes the two source values that an external register file has already read, and picks the second operand from either a register or a small signed constant held in the instruction. One clock edge later it presents the destination index, the result and a write strobe for the register file.

The block also holds a three-bit sign-classification register, {N, Z, P}. Exactly one of the three bits is set at any time. Every result this block produces refreshes the register. The load path can also refresh it through a strobe that carries the loaded value. In all other cycles the register keeps its value, and a later branch stage can read it to make its decision.

Top module: `opx_unit`

## Requirements
- R1: Opcode 4'b0001 in instr[15:12] adds the two operands, and the sum wraps modulo 2^16 with no overflow indication. With instr[5]=0 the second operand is the rs2_val input.
- R2: With instr[5]=1, for both add and AND, the second operand is instr[4:0] sign-extended to 16 bits, and rs2_val is ignored.
- R3: Opcode 4'b0101 produces the bitwise AND of the two operands.
- R4: Opcode 4'b1001 produces the bitwise complement of rs1_val and ignores rs2_val and instr[5:0].
- R5: For an operate opcode, on the next clock edge wr_en goes high for one cycle, dst equals instr[11:9] and result carries the value.
- R6: Any other opcode leaves wr_en low on the next edge.
- R7: nzp is {N,Z,P}. After an update, N=1 if the value's bit 15 is set, Z=1 if the value is zero, and P=1 otherwise. Exactly one of the three bits is high at all times.
- R8: When flag_ld is high and no operate opcode is present, nzp is classified from ld_val on the next edge. When both are present, the operate result decides the flags.
- R9: Synchronous active-high reset clears wr_en and sets nzp to 3'b010.
- R10: When there is neither an operate opcode nor flag_ld, nzp holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word |
| rs1_val | input | 16 | Value of source register 1 (index instr[8:6]) |
| rs2_val | input | 16 | Value of source register 2 (index instr[2:0]) |
| flag_ld | input | 1 | Load path asks for a flag update |
| ld_val | input | 16 | Value returned by the load path |
| dst | output | 3 | Destination register index |
| result | output | 16 | Registered operation result |
| wr_en | output | 1 | Register file write strobe |
| nzp | output | 3 | Condition flags {N,Z,P} |

## Verification
The bench targets three corner cases.
- Sums that cross 0x7FFF or 0xFFFF must show up as negative or zero. A design that saturates, or that classifies on a 17-bit sum, gives the wrong result or the wrong flags there.
- A negative 5-bit immediate must sign-extend. Zero-extending it would turn an intended subtraction into a large addition.
- A complement with garbage in rs2_val and in the low instruction bits must still return the complement of rs1_val.

The bench also sends non-operate opcodes and plain idle cycles. A design that writes on those, or that lets its flags drift, is caught there. A load strobe that arrives together with an operate instruction exposes a design that gives the load path priority.

// File: rtl/opx_pkg.sv
package opx_pkg;
  localparam int INSTR_W = 16;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_ADD  = 2'd1,
    OPK_AND  = 2'd2,
    OPK_NOT  = 2'd3
  } opk_t;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;

  localparam int NZP_N = 2;
  localparam int NZP_Z = 1;
  localparam int NZP_P = 0;
endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5,
  parameter int IDX_W  = 3
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rs1_val,
  input  logic [DATA_W-1:0]  rs2_val,
  output opk_t               kind,
  output logic [IDX_W-1:0]   dst_idx,
  output logic [DATA_W-1:0]  opa,
  output logic [DATA_W-1:0]  opb
);
  localparam int EXT_W   = DATA_W - IMM_W;
  localparam int DST_LSB = 9;
  localparam int MODE_B  = 5;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign dst_idx = instr[DST_LSB +: IDX_W];
  assign opa     = rs1_val;
  assign opb     = instr[MODE_B] ? imm_ext : rs2_val;

  always_comb begin
    unique case (instr[INSTR_W-1 -: 4])
      OPC_ADD: kind = OPK_ADD;
      OPC_AND: kind = OPK_AND;
      OPC_NOT: kind = OPK_NOT;
      default: kind = OPK_NONE;
    endcase
  end
endmodule

// File: rtl/opx_alu.sv
module opx_alu
  import opx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opk_t              kind,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (kind)
      OPK_ADD: res = opa + opb;
      OPK_AND: res = opa & opb;
      OPK_NOT: res = ~opa;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/opx_flags.sv
module opx_flags
  import opx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_upd,
  input  logic [DATA_W-1:0] op_val,
  input  logic              ld_upd,
  input  logic [DATA_W-1:0] ld_val,
  output logic [2:0]        nzp
);
  logic              upd;
  logic [DATA_W-1:0] src;
  logic [2:0]        cls;

  assign upd = op_upd | ld_upd;
  assign src = op_upd ? op_val : ld_val;

  always_comb begin
    cls = 3'b000;
    if (src[DATA_W-1])   cls[NZP_N] = 1'b1;
    else if (src == '0)  cls[NZP_Z] = 1'b1;
    else                 cls[NZP_P] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)      nzp <= 3'b010;
    else if (upd) nzp <= cls;
  end

  a_r7_flags_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(nzp) == 1);

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !upd) |=> $stable(nzp));

  a_r8_load_zero: assert property (@(posedge clk) disable iff (rst)
    (!rst && ld_upd && !op_upd && ld_val == '0) |=> nzp[NZP_Z]);
endmodule

// File: rtl/opx_unit.sv
module opx_unit
  import opx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5,
  parameter int IDX_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        instr,
  input  logic [DATA_W-1:0]  rs1_val,
  input  logic [DATA_W-1:0]  rs2_val,
  input  logic               flag_ld,
  input  logic [DATA_W-1:0]  ld_val,
  output logic [IDX_W-1:0]   dst,
  output logic [DATA_W-1:0]  result,
  output logic               wr_en,
  output logic [2:0]         nzp
);
  opk_t              kind;
  logic [IDX_W-1:0]  dec_dst;
  logic [DATA_W-1:0] opa, opb, alu_res;
  logic              is_op;

  opx_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dec (
    .instr   (instr),
    .rs1_val (rs1_val),
    .rs2_val (rs2_val),
    .kind    (kind),
    .dst_idx (dec_dst),
    .opa     (opa),
    .opb     (opb)
  );

  opx_alu #(.DATA_W(DATA_W)) u_alu (
    .kind (kind),
    .opa  (opa),
    .opb  (opb),
    .res  (alu_res)
  );

  assign is_op = (kind != OPK_NONE);

  opx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .op_upd (is_op),
    .op_val (alu_res),
    .ld_upd (flag_ld),
    .ld_val (ld_val),
    .nzp    (nzp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en  <= 1'b0;
      dst    <= '0;
      result <= '0;
    end else begin
      wr_en  <= is_op;
      dst    <= dec_dst;
      result <= alu_res;
    end
  end

  a_r6_no_write: assert property (@(posedge clk) disable iff (rst)
    (!rst && !is_op) |=> !wr_en);

  a_r5_dst_field: assert property (@(posedge clk) disable iff (rst)
    (!rst && is_op) |=> (wr_en && dst == $past(instr[11:9])));

  a_r7_sign_match: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (nzp[NZP_N] == result[DATA_W-1] && nzp[NZP_Z] == (result == '0)));

  a_r4_not_value: assert property (@(posedge clk) disable iff (rst)
    (!rst && kind == OPK_NOT) |=> result == ~$past(rs1_val));
endmodule

// File: tb/test_opx_unit.sv
module test_opx_unit;
  typedef struct {
    logic        wr;
    logic [2:0]  dst;
    logic [15:0] res;
    logic [2:0]  nzp;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0;
  logic [15:0] rs1_val = '0, rs2_val = '0, ld_val = '0;
  logic        flag_ld = 1'b0;
  logic [2:0]  dst, nzp;
  logic [15:0] result;
  logic        wr_en;

  int checks = 0;
  int fails  = 0;
  exp_t sb[$];
  logic [2:0] model_nzp = 3'b010;

  always #2 clk = ~clk;

  opx_unit i_opx_unit (
    .clk(clk), .rst(rst), .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .flag_ld(flag_ld), .ld_val(ld_val), .dst(dst), .result(result),
    .wr_en(wr_en), .nzp(nzp)
  );

  function automatic logic [2:0] classify(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] ins, input logic [15:0] a, input logic [15:0] b,
                       input logic ldu, input logic [15:0] ldv, input string tag);
    exp_t e;
    logic [15:0] opb;
    logic        op;
    @(negedge clk);
    instr = ins; rs1_val = a; rs2_val = b; flag_ld = ldu; ld_val = ldv;
    opb = ins[5] ? {{11{ins[4]}}, ins[4:0]} : b;
    op = 1'b1;
    case (ins[15:12])
      4'b0001: e.res = a + opb;
      4'b0101: e.res = a & opb;
      4'b1001: e.res = ~a;
      default: begin op = 1'b0; e.res = '0; end
    endcase
    if (op) model_nzp = classify(e.res);
    else if (ldu) model_nzp = classify(ldv);
    e.wr = op; e.dst = ins[11:9]; e.nzp = model_nzp; e.tag = tag;
    sb.push_back(e);
  endtask

  function automatic logic [15:0] mk(input logic [3:0] opc, input logic [2:0] d,
                                     input logic [2:0] s1, input logic m, input logic [4:0] lo);
    return {opc, d, s1, m, lo};
  endfunction

  // monitor: pops one expected item per cycle, one time unit after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " wr_en"}, {15'd0, wr_en}, {15'd0, e.wr});
        check({e.tag, " nzp"}, {13'd0, nzp}, {13'd0, e.nzp});
        if (e.wr) begin
          check({e.tag, " dst"}, {13'd0, dst}, {13'd0, e.dst});
          check({e.tag, " result"}, result, e.res);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset wr_en", {15'd0, wr_en}, 16'd0);
    check("R9 reset nzp", {13'd0, nzp}, 16'd2);
    @(negedge clk);
    rst = 1'b0;
    // R1 register add, including wrap
    drive(mk(4'b0001, 3'd2, 3'd3, 1'b0, 5'd4), 16'd5, 16'd7, 1'b0, 16'd0, "R1 add 5+7");
    drive(mk(4'b0001, 3'd1, 3'd0, 1'b0, 5'd1), 16'h7FFF, 16'h0001, 1'b0, 16'd0, "R1 add to 8000");
    drive(mk(4'b0001, 3'd7, 3'd6, 1'b0, 5'd0), 16'hFFFF, 16'h0001, 1'b0, 16'd0, "R1 add wrap zero");
    // R2 immediate mode, positive and negative
    drive(mk(4'b0001, 3'd4, 3'd2, 1'b1, 5'b10000), 16'd5, 16'h1234, 1'b0, 16'd0, "R2 add imm -16");
    drive(mk(4'b0001, 3'd5, 3'd2, 1'b1, 5'b01111), 16'd1, 16'hFFFF, 1'b0, 16'd0, "R2 add imm 15");
    // R3 AND register and immediate
    drive(mk(4'b0101, 3'd3, 3'd1, 1'b0, 5'd2), 16'hF0F0, 16'h3C3C, 1'b0, 16'd0, "R3 and reg");
    drive(mk(4'b0101, 3'd6, 3'd1, 1'b1, 5'b11111), 16'h8A55, 16'h0000, 1'b0, 16'd0, "R3 R2 and imm -1");
    drive(mk(4'b0101, 3'd0, 3'd1, 1'b1, 5'b00000), 16'h8A55, 16'hFFFF, 1'b0, 16'd0, "R3 and imm 0");
    // R4 NOT ignores rs2 and low bits
    drive(mk(4'b1001, 3'd2, 3'd5, 1'b0, 5'b10101), 16'h00FF, 16'hAAAA, 1'b0, 16'd0, "R4 not");
    drive(mk(4'b1001, 3'd3, 3'd5, 1'b1, 5'b11111), 16'hFFFF, 16'h0001, 1'b0, 16'd0, "R4 not to zero");
    // R6/R10 non-operate opcodes: no write, flags hold
    drive(16'h0000, 16'd0, 16'd0, 1'b0, 16'd0, "R6 R10 opcode 0000");
    drive(16'h2E05, 16'h8000, 16'd3, 1'b0, 16'h8000, "R6 R10 opcode 0010");
    drive(16'hF025, 16'h0001, 16'd1, 1'b0, 16'd0, "R6 R10 opcode 1111");
    // R8 load path updates
    drive(16'h0000, 16'd0, 16'd0, 1'b1, 16'h8001, "R8 load negative");
    drive(16'h2000, 16'd0, 16'd0, 1'b1, 16'h0042, "R8 load positive");
    drive(16'h0000, 16'd0, 16'd0, 1'b1, 16'h0000, "R8 load zero");
    drive(16'h0000, 16'd0, 16'd0, 1'b0, 16'h8000, "R10 hold after load");
    // R8 operate wins over simultaneous load; R7 classification
    drive(mk(4'b0001, 3'd1, 3'd2, 1'b1, 5'd3), 16'd2, 16'd0, 1'b1, 16'h8000, "R8 R7 op beats load");
    drive(mk(4'b0101, 3'd5, 3'd2, 1'b0, 5'd0), 16'h8000, 16'h8001, 1'b1, 16'h0005, "R8 R7 and negative");
    drive(16'h0000, 16'd0, 16'd0, 1'b0, 16'd0, "R5 R6 idle tail");
    wait (sb.size() == 0);
    @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule